// File: doc/BRIEF.md
# Receive Descriptor Write-Back Coalescer

The coalescer sits between the receive path and the host-memory write engine. Each finished receive descriptor is 16 bytes, much smaller than a 64-byte cache line, so one write per finished descriptor would fill the bus with partial-line updates. The block instead counts the finished descriptors it has not yet written back. It asks for a write-back only when that group ends on a line boundary, or when one of a few events calls for an early flush.

Finished descriptors arrive as one pulse per descriptor, in ring order. The first descriptor after reset has index 0, and indices wrap to 0 after `ring_len - 1`. Each write-back request gives a start index and a descriptor count. The request is held until the write engine acknowledges it. Three events force an early flush: the unwritten count reaching a programmable threshold, the group reaching the last ring slot, and an expiry pulse from either receive timer. `ring_len` must be a non-zero multiple of the descriptors per line, and it stays constant outside reset.

Top module: `rx_wb_coalescer`

## Requirements
- R1: After reset, `wb_req` is low, nothing is pending, and the next finished descriptor has index 0.
- R2: With no forced flush active, a pending group that reaches a line boundary is requested up to the last boundary it reaches. A line holds 4 descriptors, so a boundary falls on an index that is a multiple of 4. A group that starts mid-line therefore first writes only the rest of that line.
- R3: When `wthresh` is non-zero and the pending count is at least `wthresh`, the next request covers every pending descriptor, even if that makes a partial line.
- R4: A `wthresh` value of 0 disables the threshold flush. Pending descriptors that do not reach a line boundary stay unrequested.
- R5: A pending group that reaches index `ring_len - 1` is requested from its start up to and including that slot. Any later descriptors remain pending as a new group that starts at index 0.
- R6: A pulse on `dly_expire` or `abs_expire` flushes every pending descriptor. A pulse that leaves nothing pending issues no request, and it does not affect later descriptors.
- R7: Once raised, `wb_req`, `wb_start` and `wb_count` hold steady until `wb_ack` is sampled high. `wb_req` then falls on the next clock edge. A new request can be raised no earlier than one cycle after that.
- R8: Descriptors that finish while a request is outstanding join a new pending group. They are never added to the outstanding request.
- R9: Every request has a count of at least 1, and it starts where the previous acknowledged request ended, modulo `ring_len`.
- R10: If more than one trigger holds at once, the end-of-ring rule (R5) wins over the forced flushes (R3, R6), and the forced flushes win over the line rule (R2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| desc_done | input | 1 | One pulse per finished descriptor, in ring order |
| ring_len | input | 9 | Number of descriptors in the ring; a multiple of 4 |
| wthresh | input | 6 | Threshold for a forced flush; 0 disables it |
| dly_expire | input | 1 | Expiry pulse from the delayed receive timer |
| abs_expire | input | 1 | Expiry pulse from the absolute receive timer |
| wb_ack | input | 1 | Write engine accepts the outstanding request |
| wb_req | output | 1 | A write-back request is outstanding |
| wb_start | output | 8 | Ring index of the first descriptor to write |
| wb_count | output | 9 | Number of descriptors to write |

## Verification
The bench drives a group that starts mid-line and a group that crosses the ring end while a request is held. A design that rounds line chunks from the wrong origin would write misaligned lines. A design that lets a request wrap the ring would give a count running past the last slot. The bench also fires a timer expiry with nothing pending and sets `wthresh` to 0 with three descriptors waiting. A design that latches the expiry, or that treats a zero threshold as always met, would issue a request too early there. The bench also sets up a threshold flush and a line write that are both due at once, with the group ending past a line boundary. A wrong priority shows up there as a count of 4 instead of 5.

// File: rtl/rx_wb_pkg.sv
package rx_wb_pkg;

  // Descriptors from first up to the last line boundary that the group reaches.
  function automatic int unsigned line_span(input int unsigned first,
                                            input int unsigned cnt,
                                            input int unsigned per_line);
    int unsigned stop;
    int unsigned bound;
    stop  = first + cnt;
    bound = stop - (stop % per_line);
    return (bound > first) ? (bound - first) : 0;
  endfunction

  // Advance a ring index by step slots, wrapping at len.
  function automatic int unsigned ring_adv(input int unsigned first,
                                           input int unsigned step,
                                           input int unsigned len);
    int unsigned s;
    s = first + step;
    return (s >= len) ? (s - len) : s;
  endfunction

endpackage

// File: rtl/rx_wb_decide.sv
module rx_wb_decide #(
  parameter int IDX_W     = 8,
  parameter int LEN_W     = 9,
  parameter int THR_W     = 6,
  parameter int LINE_DESC = 4
) (
  input  logic [IDX_W-1:0] pend_start,
  input  logic [LEN_W-1:0] pend_cnt,
  input  logic [LEN_W-1:0] ring_len,
  input  logic [THR_W-1:0] wthresh,
  input  logic             tmr_flag,
  input  logic             busy,
  output logic             issue,
  output logic [LEN_W-1:0] issue_cnt,
  output logic             wrap_hit
);
  import rx_wb_pkg::*;

  logic             have;
  logic             thr_hit;
  logic             forced_hit;
  logic             line_hit;
  logic [LEN_W-1:0] chunk;
  logic [LEN_W:0]   reach;

  always_comb begin
    reach      = (LEN_W+1)'(pend_start) + (LEN_W+1)'(pend_cnt);
    have       = (pend_cnt != '0);
    wrap_hit   = have && (reach >= (LEN_W+1)'(ring_len));
    thr_hit    = (wthresh != '0) && (32'(pend_cnt) >= 32'(wthresh));
    forced_hit = have && (thr_hit || tmr_flag);
    chunk      = LEN_W'(line_span(32'(pend_start), 32'(pend_cnt), LINE_DESC));
    line_hit   = (chunk != '0);
    issue      = !busy && (wrap_hit || forced_hit || line_hit);
    if (wrap_hit)        issue_cnt = ring_len - LEN_W'(pend_start);
    else if (forced_hit) issue_cnt = pend_cnt;
    else                 issue_cnt = chunk;
  end

endmodule

// File: rtl/rx_wb_pending.sv
module rx_wb_pending #(
  parameter int IDX_W = 8,
  parameter int LEN_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             desc_done,
  input  logic             expire,
  input  logic             issue,
  input  logic             wrap_hit,
  input  logic [LEN_W-1:0] issue_cnt,
  input  logic [LEN_W-1:0] ring_len,
  output logic [IDX_W-1:0] pend_start,
  output logic [LEN_W-1:0] pend_cnt,
  output logic             tmr_flag
);
  import rx_wb_pkg::*;

  logic [IDX_W-1:0] start_d;
  logic [LEN_W-1:0] cnt_d;
  logic [LEN_W-1:0] taken;
  logic             keep;
  logic             flag_d;

  always_comb begin
    taken   = issue ? issue_cnt : '0;
    cnt_d   = pend_cnt - taken + LEN_W'(desc_done);
    start_d = issue ? IDX_W'(ring_adv(32'(pend_start), 32'(issue_cnt), 32'(ring_len)))
                    : pend_start;
    keep    = tmr_flag && !(issue && !wrap_hit);
    flag_d  = (keep || expire) && (cnt_d != '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_start <= '0;
      pend_cnt   <= '0;
      tmr_flag   <= 1'b0;
    end else begin
      pend_start <= start_d;
      pend_cnt   <= cnt_d;
      tmr_flag   <= flag_d;
    end
  end

endmodule

// File: rtl/rx_wb_req.sv
module rx_wb_req #(
  parameter int IDX_W = 8,
  parameter int LEN_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue,
  input  logic [IDX_W-1:0] issue_start,
  input  logic [LEN_W-1:0] issue_cnt,
  input  logic             ack,
  output logic             req_vld,
  output logic [IDX_W-1:0] req_start,
  output logic [LEN_W-1:0] req_cnt
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_vld   <= 1'b0;
      req_start <= '0;
      req_cnt   <= '0;
    end else if (issue) begin
      req_vld   <= 1'b1;
      req_start <= issue_start;
      req_cnt   <= issue_cnt;
    end else if (req_vld && ack) begin
      req_vld   <= 1'b0;
    end
  end

endmodule

// File: rtl/rx_wb_coalescer.sv
module rx_wb_coalescer #(
  parameter int RING_MAX   = 256,
  parameter int DESC_BYTES = 16,
  parameter int LINE_BYTES = 64,
  parameter int THR_W      = 6
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        desc_done,
  input  logic [$clog2(RING_MAX):0]   ring_len,
  input  logic [THR_W-1:0]            wthresh,
  input  logic                        dly_expire,
  input  logic                        abs_expire,
  input  logic                        wb_ack,
  output logic                        wb_req,
  output logic [$clog2(RING_MAX)-1:0] wb_start,
  output logic [$clog2(RING_MAX):0]   wb_count
);
  localparam int IDX_W     = $clog2(RING_MAX);
  localparam int LEN_W     = IDX_W + 1;
  localparam int LINE_DESC = LINE_BYTES / DESC_BYTES;

  logic [IDX_W-1:0] pend_start;
  logic [LEN_W-1:0] pend_cnt;
  logic             tmr_flag;
  logic             issue;
  logic             wrap_hit;
  logic [LEN_W-1:0] issue_cnt;
  logic             expire;

  assign expire = dly_expire | abs_expire;

  rx_wb_decide #(
    .IDX_W(IDX_W), .LEN_W(LEN_W), .THR_W(THR_W), .LINE_DESC(LINE_DESC)
  ) u_decide (
    .pend_start(pend_start),
    .pend_cnt  (pend_cnt),
    .ring_len  (ring_len),
    .wthresh   (wthresh),
    .tmr_flag  (tmr_flag),
    .busy      (wb_req),
    .issue     (issue),
    .issue_cnt (issue_cnt),
    .wrap_hit  (wrap_hit)
  );

  rx_wb_pending #(.IDX_W(IDX_W), .LEN_W(LEN_W)) u_pending (
    .clk       (clk),
    .rst_n     (rst_n),
    .desc_done (desc_done),
    .expire    (expire),
    .issue     (issue),
    .wrap_hit  (wrap_hit),
    .issue_cnt (issue_cnt),
    .ring_len  (ring_len),
    .pend_start(pend_start),
    .pend_cnt  (pend_cnt),
    .tmr_flag  (tmr_flag)
  );

  rx_wb_req #(.IDX_W(IDX_W), .LEN_W(LEN_W)) u_req (
    .clk        (clk),
    .rst_n      (rst_n),
    .issue      (issue),
    .issue_start(pend_start),
    .issue_cnt  (issue_cnt),
    .ack        (wb_ack),
    .req_vld    (wb_req),
    .req_start  (wb_start),
    .req_cnt    (wb_count)
  );

endmodule

// File: rtl/rx_wb_coalescer_chk.sv
module rx_wb_coalescer_chk #(
  parameter int IDX_W = 8,
  parameter int LEN_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LEN_W-1:0] ring_len,
  input logic             wb_ack,
  input logic             wb_req,
  input logic [IDX_W-1:0] wb_start,
  input logic [LEN_W-1:0] wb_count
);
  logic [IDX_W-1:0] exp_start;
  logic [LEN_W:0]   req_end;

  assign req_end = (LEN_W+1)'(wb_start) + (LEN_W+1)'(wb_count);

  always_ff @(posedge clk) begin
    if (!rst_n) exp_start <= '0;
    else if (wb_req && wb_ack)
      exp_start <= (req_end >= (LEN_W+1)'(ring_len)) ? '0 : IDX_W'(req_end);
  end

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req && !wb_ack |=> wb_req && $stable(wb_start) && $stable(wb_count));

  // R7
  req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req && wb_ack |=> !wb_req);

  // R9
  nonzero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req |-> wb_count != '0);

  // R9
  contiguous_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wb_req) |-> wb_start == exp_start);

  // R5
  ring_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req |-> req_end <= (LEN_W+1)'(ring_len));

endmodule

bind rx_wb_coalescer rx_wb_coalescer_chk #(.IDX_W(IDX_W), .LEN_W(LEN_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ring_len(ring_len),
  .wb_ack  (wb_ack),
  .wb_req  (wb_req),
  .wb_start(wb_start),
  .wb_count(wb_count)
);

// File: tb/rx_wb_coalescer_tb.sv
`timescale 1ns/1ps
module rx_wb_coalescer_tb_top;
  localparam int LINE = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       desc_done = 1'b0;
  logic [8:0] ring_len = 9'd16;
  logic [5:0] wthresh = 6'd0;
  logic       dly_expire = 1'b0;
  logic       abs_expire = 1'b0;
  logic       wb_ack = 1'b0;
  logic       wb_req;
  logic [7:0] wb_start;
  logic [8:0] wb_count;

  int    n_chk = 0;
  int    n_fail = 0;
  int    cyc = 0;
  bit    ack_en = 1'b0;
  bit    finished = 1'b0;
  string phase = "R1";

  // behavioural reference state
  int pend_q[$];
  int nxt_idx = 0;
  bit m_flag = 1'b0;
  bit m_req = 1'b0;
  int m_start = 0;
  int m_cnt = 0;

  always #4 clk = ~clk;

  rx_wb_coalescer dut_i (
    .clk(clk), .rst_n(rst_n), .desc_done(desc_done), .ring_len(ring_len),
    .wthresh(wthresh), .dly_expire(dly_expire), .abs_expire(abs_expire),
    .wb_ack(wb_ack), .wb_req(wb_req), .wb_start(wb_start), .wb_count(wb_count)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      pend_q.delete();
      nxt_idx = 0;
      m_flag = 1'b0;
      m_req = 1'b0;
      m_start = 0;
      m_cnt = 0;
    end else begin
      int  n;
      int  take;
      bit  fired;
      bit  by_wrap;
      n = pend_q.size();
      take = 0;
      fired = 1'b0;
      by_wrap = 1'b0;
      if (!m_req && n > 0) begin
        if (pend_q[0] + n >= int'(ring_len)) begin
          take = int'(ring_len) - pend_q[0];
          by_wrap = 1'b1;
        end else if ((wthresh != 0 && n >= int'(wthresh)) || m_flag) begin
          take = n;
        end else begin
          for (int k = n; k >= 1; k--)
            if (take == 0 && ((pend_q[0] + k) % LINE) == 0) take = k;
        end
        if (take > 0) begin
          fired = 1'b1;
          m_req = 1'b1;
          m_start = pend_q[0];
          m_cnt = take;
          repeat (take) void'(pend_q.pop_front());
        end
      end else if (m_req && wb_ack) begin
        m_req = 1'b0;
      end
      if (desc_done) begin
        pend_q.push_back(nxt_idx);
        nxt_idx = (nxt_idx + 1) % int'(ring_len);
      end
      m_flag = ((m_flag && !(fired && !by_wrap)) || dly_expire || abs_expire)
               && (pend_q.size() > 0);
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      n_chk++;
      if (wb_req !== m_req ||
          (m_req && (int'(wb_start) != m_start || int'(wb_count) != m_cnt))) begin
        n_fail++;
        $display("FAIL %s (model): actual req=%0d start=%0d count=%0d expected req=%0d start=%0d count=%0d",
                 phase, wb_req, wb_start, wb_count, m_req, m_start, m_cnt);
      end
    end
  end

  task automatic report();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !finished) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual %0d cycles expected below 20000", cyc);
      report();
    end
  end

  task automatic step(input bit d, input bit dly, input bit abs_t);
    @(negedge clk);
    desc_done  = d;
    dly_expire = dly;
    abs_expire = abs_t;
    wb_ack     = ack_en && wb_req;
  endtask

  task automatic dones(input int k);
    for (int i = 0; i < k; i++) step(1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0);
  endtask

  task automatic ack_pulse();
    ack_en = 1'b1;
    step(1'b0, 1'b0, 1'b0);
    ack_en = 1'b0;
    step(1'b0, 1'b0, 1'b0);
  endtask

  task automatic wait_req(input string tag, input int s, input int c);
    for (int i = 0; i < 8; i++) if (!wb_req) step(1'b0, 1'b0, 1'b0);
    chk({tag, " req"}, int'(wb_req), 1);
    chk({tag, " start"}, int'(wb_start), s);
    chk({tag, " count"}, int'(wb_count), c);
  endtask

  task automatic do_reset(input int len, input int th);
    rst_n = 1'b0;
    ring_len = 9'(len);
    wthresh = 6'(th);
    ack_en = 1'b0;
    repeat (3) step(1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    step(1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    // Pass 1: ring of 16, threshold disabled
    do_reset(16, 0);
    phase = "R1";
    chk("R1 reset req", int'(wb_req), 0);

    phase = "R4";
    dones(3);
    repeat (3) step(1'b0, 1'b0, 1'b0);
    chk("R4 three pending, wthresh 0", int'(wb_req), 0);

    phase = "R2";
    dones(1);
    wait_req("R2 full line", 0, 4);

    phase = "R8";
    dones(2);
    step(1'b0, 1'b0, 1'b0);
    wait_req("R7 R8 held while busy", 0, 4);
    phase = "R7";
    ack_pulse();
    chk("R7 drop after ack", int'(wb_req), 0);

    phase = "R6";
    step(1'b0, 1'b1, 1'b0);
    wait_req("R6 R9 delayed timer flush", 4, 2);
    ack_pulse();
    step(1'b0, 1'b0, 1'b1);
    repeat (4) step(1'b0, 1'b0, 1'b0);
    chk("R6 expiry with nothing pending", int'(wb_req), 0);
    dones(1);
    repeat (3) step(1'b0, 1'b0, 1'b0);
    chk("R6 stale expiry has no effect", int'(wb_req), 0);

    phase = "R2";
    dones(1);
    wait_req("R2 mid-line realign", 6, 2);
    ack_pulse();

    phase = "R3";
    wthresh = 6'd3;
    dones(3);
    wait_req("R3 threshold flush", 8, 3);
    ack_pulse();

    // Pass 2: forced flush beats the line rule
    do_reset(16, 5);
    phase = "R10";
    dones(4);
    wait_req("R10 first line", 0, 4);
    dones(5);
    ack_pulse();
    wait_req("R10 threshold over line", 4, 5);
    ack_pulse();

    // Pass 3: ring of 8, group crossing the end
    do_reset(8, 0);
    phase = "R5";
    dones(4);
    wait_req("R5 first line", 0, 4);
    dones(6);
    wthresh = 6'd2;
    ack_pulse();
    wait_req("R5 R10 stop at ring end", 4, 4);
    ack_pulse();
    wait_req("R3 R9 remainder from zero", 0, 2);
    ack_pulse();

    phase = "R6";
    wthresh = 6'd0;
    dones(1);
    step(1'b0, 1'b0, 1'b1);
    wait_req("R6 absolute timer flush", 2, 1);
    ack_pulse();
    repeat (3) step(1'b0, 1'b0, 1'b0);
    chk("R9 idle after last ack", int'(wb_req), 0);

    report();
  end

endmodule